// File: doc/BRIEF.md
# Multi-way tag ECC error logger

This block sits between a set-associative tag array and the hit-compare logic of a cache. On every probe it receives all ways read at one index, each as a 19-bit tag word (valid, dirty and lock bits plus a 16-bit tag) with a 6-bit SEC/DED check field. All ways are checked in parallel. A single-bit error is repaired before the tag leaves the block, so the hit comparison always sees clean data. A double-bit error is only reported.

Software sees two sticky flags, one for correctable and one for uncorrectable errors, plus one captured record: the probe index, the hit way and the hit way's syndrome. A zero captured syndrome means the failing word was in a way that did not hit. A double-bit event replaces an earlier single-bit record. A single-bit event never replaces any record. A small write port loads the ECC and interrupt enables and clears the flags. A registered interrupt line combines each flag with its enable.

Top module: `tag_ecc_logger`

## Requirements
- R1: After reset both flags, the captured index, way and syndrome, and `irq_o` are zero, and ECC, correctable interrupt and uncorrectable interrupt enables are all off.
- R2: Check code: data bit i (bit 0 = LSB of the tag word) is given the (i+1)-th integer of 3 and above that is not a power of two. Check bits [4:0] are the XOR of the codes of all set data bits. Check bit 5 makes the parity of the 19 data bits and check bits [4:0] even. The syndrome is {overall parity mismatch, recomputed [4:0] XOR stored [4:0]}.
- R3: With ECC on, a single flipped bit in any way, in data or in check bits, gives that way's clean tag on `tags_o` in the same cycle. It also sets `sec_flag_o` at the next clock edge after a valid probe.
- R4: With ECC on, two flipped bits in one way set `ded_flag_o` at the next edge, and that way's tag passes through `tags_o` unchanged.
- R5: With ECC off, `tags_o` equals `tags_i` and no probe sets either flag.
- R6: When no flag is set, an erroneous probe captures the index (low 10 bits on `cap_idx_lo_o`, bit 10 on `cap_idx_hi_o`). If the hit way is in error, it also captures that way's syndrome and number. Otherwise it captures syndrome zero and way zero.
- R7: A probe with only single-bit errors leaves the capture unchanged while either flag is set.
- R8: A double-bit probe replaces a capture made by a single-bit event. It does not replace one that is already held with `ded_flag_o` set.
- R9: Write port `cfg_wdata_i`: bit 0 is the ECC enable, bit 1 the correctable interrupt enable, bit 2 the uncorrectable interrupt enable. Writing 1 to bit 3 clears `sec_flag_o` and writing 1 to bit 4 clears `ded_flag_o`. Capture is re-armed only when both flags are clear.
- R10: `irq_o` is registered. It equals (sec flag AND its enable) OR (ded flag AND its enable) as held one edge earlier.
- R11: Inputs present while `probe_valid_i` is low change neither flags nor capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_valid_i | input | 1 | Probe present this cycle |
| probe_idx_i | input | 11 | Index of the probed set |
| hit_way_i | input | 3 | Way that hit for this probe |
| tags_i | input | 152 | Raw tag words, way w at bits [19w+18:19w] |
| chks_i | input | 48 | Check fields, way w at bits [6w+5:6w] |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 5 | Control word, see R9 |
| tags_o | output | 152 | Corrected tag words, same layout as `tags_i` |
| sec_flag_o | output | 1 | Sticky correctable error flag |
| ded_flag_o | output | 1 | Sticky uncorrectable error flag |
| cap_idx_lo_o | output | 10 | Captured index, low part |
| cap_idx_hi_o | output | 1 | Captured index, upper bit |
| cap_way_o | output | 3 | Captured failing hit way |
| cap_syn_o | output | 6 | Captured hit-way syndrome |
| irq_o | output | 1 | Registered interrupt |

## Verification
The assertions assume that a probe carries at most two flipped bits per way. A triple flip can alias to a single-bit syndrome and would be miscorrected, which no code of this strength can prevent. They also assume that `hit_way_i` names a way that exists. The stimulus builds every word from a clean encoding and flips either zero, one or two chosen bits in one selected way. The hit way is always drawn from 0 to 7. The uncorrectable-capture checks therefore cover both hit and non-hit cases without leaving that domain.

// File: rtl/tag_ecc_pkg.sv
package tag_ecc_pkg;
  localparam int TAG_W     = 19;
  localparam int CHK_W     = 6;
  localparam int POS_W     = CHK_W - 1;
  localparam int CFG_W     = 5;
  localparam int CFG_ECC   = 0;
  localparam int CFG_SIE   = 1;
  localparam int CFG_DIE   = 2;
  localparam int CFG_CSEC  = 3;
  localparam int CFG_CDED  = 4;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [CHK_W-1:0] chk_t;

  // position code of data bit i: the i-th non-power-of-two starting at 3
  function automatic logic [POS_W-1:0] bit_code(input int i);
    logic [POS_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int k = 3; k < (1 << POS_W); k++) begin
      if ((k & (k - 1)) != 0) begin
        if (n == i) r = POS_W'(k);
        n++;
      end
    end
    return r;
  endfunction

  function automatic chk_t chk_gen(input tag_t d);
    logic [POS_W-1:0] s;
    s = '0;
    for (int i = 0; i < TAG_W; i++) if (d[i]) s ^= bit_code(i);
    return {^{d, s}, s};
  endfunction
endpackage

// File: rtl/tag_ecc_way.sv
module tag_ecc_way
  import tag_ecc_pkg::*;
(
  input  logic ecc_en_i,
  input  tag_t tag_i,
  input  chk_t chk_i,
  output tag_t tag_o,
  output logic sbe_o,
  output logic dbe_o,
  output chk_t syn_o
);
  chk_t             calc;
  logic [POS_W-1:0] s;
  logic             p;
  tag_t             fix;
  logic             chk_loc;

  always_comb begin
    calc = chk_gen(tag_i);
    s    = calc[POS_W-1:0] ^ chk_i[POS_W-1:0];
    p    = ^{tag_i, chk_i};
  end

  for (genvar i = 0; i < TAG_W; i++) begin : g_fix
    assign fix[i] = (s == bit_code(i));
  end

  // zero or one-hot position code points at a check bit
  assign chk_loc = $onehot0(s);
  assign sbe_o   = ecc_en_i & p & (chk_loc | (|fix));
  assign dbe_o   = ecc_en_i & ~sbe_o & (p | (|s));
  assign syn_o   = ecc_en_i ? {p, s} : '0;
  assign tag_o   = sbe_o ? (tag_i ^ fix) : tag_i;

  always_comb begin
    a_r3_excl_class: assert (!(sbe_o && dbe_o));
    a_r3_one_bit_fix: assert ($countones(tag_o ^ tag_i) <= 1);
  end
endmodule

// File: rtl/tag_ecc_capture.sv
module tag_ecc_capture #(
  parameter int IDX_W = 11,
  parameter int WAY_W = 3,
  parameter int SYN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             probe_valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sbe_any_i,
  input  logic             dbe_any_i,
  input  logic             hit_err_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [SYN_W-1:0] hit_syn_i,
  input  logic             clr_sec_i,
  input  logic             clr_ded_i,
  output logic             sec_flag_o,
  output logic             ded_flag_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic [WAY_W-1:0] cap_way_o,
  output logic [SYN_W-1:0] cap_syn_o
);
  logic sec_held, ded_held, armed, take;

  assign sec_held = sec_flag_o & ~clr_sec_i;
  assign ded_held = ded_flag_o & ~clr_ded_i;
  assign armed    = ~sec_held & ~ded_held;
  // double-bit replaces anything but an earlier double-bit record
  assign take     = probe_valid_i &
                    ((dbe_any_i & ~ded_held) | (sbe_any_i & ~dbe_any_i & armed));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_flag_o <= 1'b0;
      ded_flag_o <= 1'b0;
      cap_idx_o  <= '0;
      cap_way_o  <= '0;
      cap_syn_o  <= '0;
    end else begin
      sec_flag_o <= sec_held | (probe_valid_i & sbe_any_i);
      ded_flag_o <= ded_held | (probe_valid_i & dbe_any_i);
      if (take) begin
        cap_idx_o <= idx_i;
        cap_way_o <= hit_err_i ? hit_way_i : '0;
        cap_syn_o <= hit_err_i ? hit_syn_i : '0;
      end
    end
  end

  a_r7_sec_keeps_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sec_flag_o || ded_flag_o) && !$past(clr_sec_i || clr_ded_i) &&
     !$past(probe_valid_i && dbe_any_i)) |-> $stable(cap_idx_o));

  a_r8_ded_keeps_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ded_flag_o) && !$past(clr_ded_i)) |-> ($stable(cap_idx_o) && $stable(cap_syn_o)));

  a_r9_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sec_i && clr_ded_i && !probe_valid_i) |=> (!sec_flag_o && !ded_flag_o));

  a_r11_idle_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!probe_valid_i && !sec_flag_o && !ded_flag_o) |=> (!sec_flag_o && !ded_flag_o));
endmodule

// File: rtl/tag_ecc_logger.sv
module tag_ecc_logger
  import tag_ecc_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int IDX_W    = 11,
  parameter int IDX_LO_W = 10,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_HI_W = IDX_W - IDX_LO_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   probe_valid_i,
  input  logic [IDX_W-1:0]       probe_idx_i,
  input  logic [WAY_W-1:0]       hit_way_i,
  input  logic [WAYS*TAG_W-1:0]  tags_i,
  input  logic [WAYS*CHK_W-1:0]  chks_i,
  input  logic                   cfg_we_i,
  input  logic [CFG_W-1:0]       cfg_wdata_i,
  output logic [WAYS*TAG_W-1:0]  tags_o,
  output logic                   sec_flag_o,
  output logic                   ded_flag_o,
  output logic [IDX_LO_W-1:0]    cap_idx_lo_o,
  output logic [IDX_HI_W-1:0]    cap_idx_hi_o,
  output logic [WAY_W-1:0]       cap_way_o,
  output logic [CHK_W-1:0]       cap_syn_o,
  output logic                   irq_o
);
  logic            ecc_en_q, sec_ie_q, ded_ie_q;
  logic [WAYS-1:0] sbe_w, dbe_w;
  chk_t            syn_w [WAYS];
  logic            sbe_any, dbe_any, hit_err;
  logic [IDX_W-1:0] cap_idx;
  logic            clr_sec, clr_ded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_en_q <= 1'b0;
      sec_ie_q <= 1'b0;
      ded_ie_q <= 1'b0;
    end else if (cfg_we_i) begin
      ecc_en_q <= cfg_wdata_i[CFG_ECC];
      sec_ie_q <= cfg_wdata_i[CFG_SIE];
      ded_ie_q <= cfg_wdata_i[CFG_DIE];
    end
  end

  assign clr_sec = cfg_we_i & cfg_wdata_i[CFG_CSEC];
  assign clr_ded = cfg_we_i & cfg_wdata_i[CFG_CDED];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_ecc_way i_way (
      .ecc_en_i (ecc_en_q),
      .tag_i    (tags_i[w*TAG_W +: TAG_W]),
      .chk_i    (chks_i[w*CHK_W +: CHK_W]),
      .tag_o    (tags_o[w*TAG_W +: TAG_W]),
      .sbe_o    (sbe_w[w]),
      .dbe_o    (dbe_w[w]),
      .syn_o    (syn_w[w])
    );
  end

  assign sbe_any = |sbe_w;
  assign dbe_any = |dbe_w;
  assign hit_err = sbe_w[hit_way_i] | dbe_w[hit_way_i];

  tag_ecc_capture #(
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .SYN_W (CHK_W)
  ) i_capture (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .probe_valid_i (probe_valid_i),
    .idx_i         (probe_idx_i),
    .sbe_any_i     (sbe_any),
    .dbe_any_i     (dbe_any),
    .hit_err_i     (hit_err),
    .hit_way_i     (hit_way_i),
    .hit_syn_i     (syn_w[hit_way_i]),
    .clr_sec_i     (clr_sec),
    .clr_ded_i     (clr_ded),
    .sec_flag_o    (sec_flag_o),
    .ded_flag_o    (ded_flag_o),
    .cap_idx_o     (cap_idx),
    .cap_way_o     (cap_way_o),
    .cap_syn_o     (cap_syn_o)
  );

  assign cap_idx_lo_o = cap_idx[IDX_LO_W-1:0];
  assign cap_idx_hi_o = cap_idx[IDX_W-1:IDX_LO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (sec_flag_o & sec_ie_q) | (ded_flag_o & ded_ie_q);
  end

  a_r10_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(sec_flag_o) || $past(ded_flag_o)));

  a_r5_off_is_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ecc_en_q |-> (!sbe_any && !dbe_any && (tags_o == tags_i)));

  a_r6_way_needs_syn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_syn_o == '0) |-> (cap_way_o == '0));
endmodule

// File: tb/test_tag_ecc_logger.sv
module test_tag_ecc_logger;
  localparam int WAYS = 8;
  localparam int TW   = 19;
  localparam int CW   = 6;
  localparam int NV   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic probe_valid = 1'b0;
  logic [10:0] probe_idx = '0;
  logic [2:0]  hit_way = '0;
  logic [WAYS*TW-1:0] tags_in = '0;
  logic [WAYS*CW-1:0] chks_in = '0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [WAYS*TW-1:0] tags_out;
  logic sec_flag, ded_flag, cap_hi, irq;
  logic [9:0] cap_lo;
  logic [2:0] cap_way;
  logic [5:0] cap_syn;

  int checks = 0;
  int errors = 0;
  logic ecc_on = 1'b0;
  logic e_sbe, e_dbe;
  logic [5:0] e_syn;
  logic [2:0] e_way;

  always #2.5 clk = ~clk;

  tag_ecc_logger i_tag_ecc_logger (
    .clk_i(clk), .rst_ni(rst_n), .probe_valid_i(probe_valid), .probe_idx_i(probe_idx),
    .hit_way_i(hit_way), .tags_i(tags_in), .chks_i(chks_in), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .tags_o(tags_out), .sec_flag_o(sec_flag), .ded_flag_o(ded_flag),
    .cap_idx_lo_o(cap_lo), .cap_idx_hi_o(cap_hi), .cap_way_o(cap_way), .cap_syn_o(cap_syn),
    .irq_o(irq));

  // vector: {err_way[3:0] (8 = none), bit_a[4:0], bit_b[4:0] (31 = none), hit[2:0], idx[10:0]}
  localparam logic [27:0] VEC [NV] = '{
    {4'd3, 5'd5,  5'd31, 3'd3, 11'h012},
    {4'd7, 5'd18, 5'd31, 3'd2, 11'h7FF},
    {4'd0, 5'd19, 5'd31, 3'd0, 11'h400},
    {4'd5, 5'd24, 5'd31, 3'd5, 11'h2A1},
    {4'd1, 5'd2,  5'd9,  3'd1, 11'h155},
    {4'd6, 5'd20, 5'd0,  3'd4, 11'h600},
    {4'd2, 5'd0,  5'd31, 3'd2, 11'h0FF},
    {4'd4, 5'd24, 5'd18, 3'd4, 11'h3C3},
    {4'd8, 5'd0,  5'd31, 3'd7, 11'h111}
  };

  function automatic logic [4:0] b_code(input int i);
    int n = 0;
    logic [4:0] r = '0;
    for (int k = 3; k < 32; k++) begin
      if ((k & (k - 1)) != 0) begin
        if (n == i) r = 5'(k);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] b_enc(input logic [TW-1:0] d);
    logic [4:0] s = '0;
    for (int i = 0; i < TW; i++) if (d[i]) s ^= b_code(i);
    return {^{d, s}, s};
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    ecc_on = w[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one probe, checks tags_o, returns one negedge after the capturing edge
  task automatic probe(input logic v, input logic [10:0] idx, input logic [2:0] hit,
                       input int ew, input int a, input int b, input string req);
    logic [WAYS*TW-1:0] exp_tags;
    @(negedge clk);
    e_sbe = 1'b0; e_dbe = 1'b0; e_syn = '0; e_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      logic [TW-1:0] d;
      logic [24:0] cw;
      logic [4:0] s;
      logic p;
      d  = TW'(idx * 131 + w * 7919 + 12345);
      cw = {b_enc(d), d};
      if (w == ew) begin
        cw[a] = ~cw[a];
        if (b != 31) cw[b] = ~cw[b];
      end
      tags_in[w*TW +: TW] = cw[18:0];
      chks_in[w*CW +: CW] = cw[24:19];
      exp_tags[w*TW +: TW] = cw[18:0];
      if (w == ew && ecc_on) begin
        s = b_enc(cw[18:0])[4:0] ^ cw[23:19];
        p = ^cw;
        if (b == 31) begin
          e_sbe = 1'b1;
          exp_tags[w*TW +: TW] = d;
        end else e_dbe = 1'b1;
        if (w == int'(hit)) begin
          e_syn = {p, s};
          e_way = hit;
        end
      end
    end
    probe_valid = v;
    probe_idx = idx;
    hit_way = hit;
    #1;
    check({req, " tags_o"}, 160'(tags_out), 160'(exp_tags));
    @(negedge clk);
    probe_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", 160'({sec_flag, ded_flag, irq}), 160'(0));
    check("R1 capture", 160'({cap_hi, cap_lo, cap_way, cap_syn}), 160'(0));
    // R1/R5 ECC is off after reset: no correction, no flags
    probe(1'b1, 11'h010, 3'd1, 1, 4, 31, "R5");
    check("R5 flags off", 160'({sec_flag, ded_flag}), 160'(0));

    // table walk, each from a cleared state with all enables on (R2 R3 R4 R6 R10)
    for (int n = 0; n < NV; n++) begin
      logic [27:0] v;
      v = VEC[n];
      cfg_write(5'b11111);
      probe(1'b1, v[10:0], v[13:11], int'(v[27:24]), int'(v[23:19]), int'(v[18:14]), "R3/R4");
      check("R3 sec_flag", 160'(sec_flag), 160'(e_sbe));
      check("R4 ded_flag", 160'(ded_flag), 160'(e_dbe));
      if (e_sbe || e_dbe) begin
        check("R6 cap idx", 160'({cap_hi, cap_lo}), 160'(v[10:0]));
        check("R2 cap syn", 160'(cap_syn), 160'(e_syn));
        check("R6 cap way", 160'(cap_way), 160'(e_way));
      end
      @(negedge clk);
      check("R10 irq", 160'(irq), 160'(e_sbe | e_dbe));
    end

    // R7 single-bit does not overwrite
    cfg_write(5'b11111);
    probe(1'b1, 11'h0A5, 3'd2, 2, 7, 31, "R7");
    probe(1'b1, 11'h123, 3'd2, 2, 3, 31, "R7");
    check("R7 idx kept", 160'({cap_hi, cap_lo}), 160'(11'h0A5));

    // R8 double overwrites single, but not double
    probe(1'b1, 11'h4F0, 3'd1, 1, 0, 1, "R8");
    check("R8 idx replaced", 160'({cap_hi, cap_lo}), 160'(11'h4F0));
    check("R8 flags", 160'({sec_flag, ded_flag}), 160'(2'b11));
    check("R8 way", 160'(cap_way), 160'(3'd1));
    probe(1'b1, 11'h333, 3'd3, 3, 5, 6, "R8");
    check("R8 idx kept", 160'({cap_hi, cap_lo}), 160'(11'h4F0));
    check("R8 way kept", 160'(cap_way), 160'(3'd1));

    // R9 clear only sec: still not armed
    cfg_write(5'b01111);
    check("R9 sec cleared", 160'({sec_flag, ded_flag}), 160'(2'b01));
    probe(1'b1, 11'h055, 3'd0, 0, 3, 31, "R9");
    check("R9 not armed", 160'({cap_hi, cap_lo}), 160'(11'h4F0));
    cfg_write(5'b11111);
    check("R9 both cleared", 160'({sec_flag, ded_flag}), 160'(0));
    probe(1'b1, 11'h066, 3'd0, 0, 3, 31, "R9");
    check("R9 re-armed", 160'({cap_hi, cap_lo}), 160'(11'h066));

    // R10 uncorrectable interrupt masked, then enabled
    cfg_write(5'b11011);
    probe(1'b1, 11'h077, 3'd5, 5, 1, 2, "R10");
    @(negedge clk);
    check("R10 masked", 160'({ded_flag, irq}), 160'(2'b10));
    cfg_write(5'b00101);
    @(negedge clk);
    check("R10 enabled", 160'(irq), 160'(1));

    // R11 errors without probe_valid leave state alone
    cfg_write(5'b11111);
    probe(1'b0, 11'h222, 3'd6, 6, 1, 31, "R11");
    check("R11 flags", 160'({sec_flag, ded_flag}), 160'(0));
    check("R11 capture", 160'({cap_hi, cap_lo}), 160'(11'h077));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule